// File: doc/BRIEF.md
# Cascaded 2/3 Cell Programmable Divider

This block divides a fast clock by an integer ratio chosen by a control word. It sits in the feedback path of an integer-N synthesizer, where the fast clock stands for the oscillator output and the divided pulse goes to the phase comparator. The ratio comes from a chain of identical divide-by-2/3 cells, not from one loadable counter. Each cell owns one bit of the control word. Each cell hands its divided event stream forward to the next cell. A modulus signal travels back from the far end of the chain toward the input and tells each cell when it may swallow one extra input event.

With `CELLS` stages the ratio is 2^CELLS plus the unsigned value of the control word. For the default of eight cells this covers 256 to 511. The synthesizer band of 480 to 496 sits inside that range. A 3-bit oscillator subband code is taken from the same latched word. The control word is latched only when the chain wraps, so the ratio and the subband never change inside an output period.

Top module: `div23_chain`

## Requirements
- R1: The number of `clk` rising edges between two successive `div_clk` pulses equals 2^CELLS + W. W is the unsigned value of the latched control word, and bit k of `ctrl` (bit 0 belongs to the cell nearest `clk`) adds 2^k. With the default of eight cells, every word from 224 to 255 gives a ratio from 480 to 511.
- R2: `div_clk` is high for exactly one `clk` cycle per output period.
- R3: The extremes of the range hold: word 0 gives 256, word 255 gives 511, word 1 gives 257 and word 128 gives 384.
- R4: `ctrl` is sampled only on the edge that raises `div_clk`. The period that starts with that pulse uses the sampled value. A change of `ctrl` at any other time leaves the current period unchanged.
- R5: While `rst` (synchronous, active high) is asserted, `div_clk` is 0 and the word latch loads `ctrl`. The first `div_clk` pulse appears on the N-th rising edge after the first edge with `rst` low, where N is the R1 ratio.
- R6: `band` equals bits 3 down to 1 of the latched word. It changes only on the edge that raises `div_clk`, or during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | CELLS | Division control word, one bit per cell |
| div_clk | output | 1 | One-cycle pulse once per output period |
| band | output | 3 | Oscillator subband code from the latched word |

## Verification
The bench sweeps every word from 224 to 255 and measures each output period. A cell that swallowed at the wrong time, or a modulus chain that wrapped early, would show up as a period that is off by a power of two. The end words 0, 1, 128 and 255 are run because a cell-count or carry mistake shows first at those points. Each new word is applied just after a pulse, and once again in the middle of a period. The period in progress must keep the old ratio, so a divider that reloaded at once would give a short or mixed period. The bench also checks the first period after reset and confirms that `band` does not move until the boundary; a design that passed `ctrl` straight through would fail there.

// File: rtl/div23_pkg.sv
package div23_pkg;

    // Per-cell count of input events seen in the current cell cycle.
    typedef logic [1:0] cell_cnt_t;

    // Snapshot of the control word together with its subband field.
    typedef struct packed {
        logic [7:0] word;
        logic [2:0] band;
    } word_snap_t;

    // Ratio produced by a chain of n cells driven by the given word.
    function automatic int unsigned chain_ratio(input int unsigned cells,
                                                input int unsigned word);
        return (32'd1 << cells) + word;
    endfunction

    // Last count value of a cell: 2 when it swallows, otherwise 1.
    function automatic cell_cnt_t cell_last(input logic swallow);
        return swallow ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/div23_cell.sv
module div23_cell
    import div23_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ev_in,
    input  logic mod_in,
    input  logic p_bit,
    output logic ev_out,
    output logic mod_out
);

    cell_cnt_t cnt_q;
    logic      swallow;
    logic      at_last;

    // One extra input event is taken only in the cycle the next stage marks.
    assign swallow = p_bit & mod_in;
    assign at_last = (cnt_q == cell_last(swallow));
    assign ev_out  = ev_in & at_last;
    assign mod_out = mod_in & at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ev_in) begin
            cnt_q <= at_last ? '0 : cnt_q + 2'd1;
        end
    end

endmodule

// File: rtl/div23_word_reg.sv
module div23_word_reg
    import div23_pkg::*;
#(
    parameter int CELLS   = 8,
    parameter int BAND_LO = 1,
    parameter int BAND_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap,
    input  logic [CELLS-1:0]  ctrl,
    output logic [CELLS-1:0]  word_q,
    output logic [BAND_W-1:0] band_q
);

    localparam int BAND_HI = BAND_LO + BAND_W - 1;

    // The word and its subband are loaded together, only at a chain wrap.
    always_ff @(posedge clk) begin
        if (rst || wrap) begin
            word_q <= ctrl;
            band_q <= ctrl[BAND_HI:BAND_LO];
        end
    end

endmodule

// File: rtl/div23_chain.sv
module div23_chain
    import div23_pkg::*;
#(
    parameter int CELLS   = 8,
    parameter int BAND_LO = 1,
    parameter int BAND_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CELLS-1:0]  ctrl,
    output logic              div_clk,
    output logic [BAND_W-1:0] band
);

    logic             ev_w [0:CELLS];
    logic             md_w [0:CELLS];
    logic [CELLS-1:0] word_q;
    logic             wrap;

    assign ev_w[0]     = 1'b1;
    assign md_w[CELLS] = 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < CELLS; gi++) begin : g_cell
            div23_cell u_cell (
                .clk    (clk),
                .rst    (rst),
                .ev_in  (ev_w[gi]),
                .mod_in (md_w[gi+1]),
                .p_bit  (word_q[gi]),
                .ev_out (ev_w[gi+1]),
                .mod_out(md_w[gi])
            );
        end
    endgenerate

    // The whole chain completes when the modulus reaches the first cell
    // and the last cell's event passes out of the chain.
    assign wrap = ev_w[CELLS] & md_w[0];

    div23_word_reg #(
        .CELLS  (CELLS),
        .BAND_LO(BAND_LO),
        .BAND_W (BAND_W)
    ) u_word (
        .clk   (clk),
        .rst   (rst),
        .wrap  (wrap),
        .ctrl  (ctrl),
        .word_q(word_q),
        .band_q(band)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            div_clk <= 1'b0;
        end else begin
            div_clk <= wrap;
        end
    end

endmodule

// File: rtl/div23_chain_chk.sv
module div23_chain_chk
    import div23_pkg::*;
#(
    parameter int CELLS  = 8,
    parameter int BAND_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              div_clk,
    input logic [BAND_W-1:0] band
);

    localparam int GAP_W  = CELLS + 2;
    localparam int GAP_LO = chain_ratio(CELLS, 0);
    localparam int GAP_HI = chain_ratio(CELLS, (1 << CELLS) - 1);

    logic [GAP_W-1:0] gap_q;
    logic             armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            gap_q   <= div_clk ? GAP_W'(1) : gap_q + GAP_W'(1);
            armed_q <= 1'b1;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        div_clk |=> !div_clk); // R2

    AST_GAP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        div_clk |-> (gap_q >= GAP_W'(GAP_LO)) && (gap_q <= GAP_W'(GAP_HI))); // R1

    AST_BAND_HELD: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !div_clk) |-> $stable(band)); // R6

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !div_clk); // R5

endmodule

bind div23_chain div23_chain_chk #(
    .CELLS (CELLS),
    .BAND_W(BAND_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .div_clk(div_clk),
    .band   (band)
);

// File: tb/sim_div23_chain.sv
module sim_div23_chain;

    localparam int CELLS = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CELLS-1:0] ctrl = 8'd224;
    logic             div_clk;
    logic [2:0]       band;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    div23_chain #(.CELLS(CELLS)) u0 (
        .clk    (clk),
        .rst    (rst),
        .ctrl   (ctrl),
        .div_clk(div_clk),
        .band   (band)
    );

    function automatic int ratio_of(input int w);
        return (1 << CELLS) + w;
    endfunction

    function automatic logic [2:0] band_of(input int w);
        return 3'((w >> 1) & 7);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts edges until div_clk is seen high; the first edge after a pulse
    // must show div_clk low again (R2).
    task automatic wait_pulse(input logic after_pulse, output int n);
        n = 0;
        while (1) begin
            @(posedge clk);
            #1;
            n++;
            if (after_pulse && n == 1) check("R2 pulse width", int'(div_clk), 0);
            if (div_clk) break;
            if (n > 2000) break;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step_word(input int old_w, input int new_w, input string req);
        int n;
        ctrl = CELLS'(new_w);
        check({req, " band held"}, int'(band), int'(band_of(old_w)));   // R6
        wait_pulse(1'b1, n);
        check({req, " R4 old period"}, n, ratio_of(old_w));
        check({req, " R6 band update"}, int'(band), int'(band_of(new_w)));
        wait_pulse(1'b1, n);
        check(req, n, ratio_of(new_w));
    endtask

    initial begin
        int n;
        int prev;
        repeat (4) @(posedge clk);
        #1;
        check("R5 reset div_clk", int'(div_clk), 0);
        check("R5 reset band", int'(band), int'(band_of(224)));
        @(negedge clk);
        rst = 1'b0;
        wait_pulse(1'b0, n);
        check("R5 first period", n, ratio_of(224));

        // R1 sweep over the synthesizer range and beyond
        prev = 224;
        for (int w = 225; w <= 255; w++) begin
            step_word(prev, w, "R1 sweep");
            prev = w;
        end

        // R3 range extremes
        step_word(prev, 0, "R3 word0");
        step_word(0, 1, "R3 word1");
        step_word(1, 128, "R3 word128");
        step_word(128, 255, "R3 word255");

        // R4 change in the middle of a period
        repeat (100) @(posedge clk);
        #1;
        ctrl = 8'd233;
        wait_pulse(1'b0, n);
        check("R4 mid change", n, ratio_of(255) - 100);
        check("R6 band mid change", int'(band), int'(band_of(233)));
        wait_pulse(1'b1, n);
        check("R4 new period", n, ratio_of(233));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule